// File: doc/BRIEF.md
# Video Controller Register Slave with Blanking-Synchronised Update

This block is the serial control port of a video processing chip. A host on a two-wire I2C bus writes bytes into sixteen byte-wide registers selected by a subaddress. The registers drive the video path's controls (brightness, saturation, contrast, gains, limit level and two control words) as a flat vector. The block only receives: the host can never read back, and the block never stretches the clock. Both bus lines are sampled into the system clock domain, and the block acknowledges by pulling the data line low through an open-drain enable.

Writes take effect in one of two ways, chosen by a buffer-enable bit held in the block's own control register at subaddress 0CH. When the bit is clear, each accepted data byte lands in its live register at once, and a burst advances the subaddress with wrap-around. When the bit is set, a transfer carries a single data byte. That byte is parked and copied into the live register on the next rising edge of the vertical blanking input, so a picture change never tears mid-frame. Until that copy happens, further data bytes are refused.

Top module: `vrs_regslave`

## Requirements
- R1: While rst_n is low, and right after it rises, all sixteen live registers read 01H and the data line is not pulled.
- R2: Only the address byte 88H (7-bit address 1000100, write direction) is acknowledged; any other first byte, including 89H, is refused and every later byte of that transfer is refused and stores nothing.
- R3: A subaddress byte from 00H to 0FH is acknowledged; a subaddress above 0FH is refused and the data bytes after it are refused and store nothing.
- R4: With the buffer-enable bit (bit 5 of register 0CH) at 0, every data byte is acknowledged and written into its live register as soon as its eighth bit is in. Successive bytes of one transfer go to consecutive subaddresses, and 0FH is followed by 00H.
- R5: Subaddresses 07H, 08H, 09H, 0BH, 0EH and 0FH acknowledge data, but their registers stay at 01H and no other register changes.
- R6: With the buffer-enable bit at 1, the first data byte of a transfer is acknowledged; the second and later ones are refused and not stored.
- R7: A data byte accepted with the buffer-enable bit at 1 leaves the live register untouched until the next rising edge of vblank_i, after which it holds the new value.
- R8: While a buffered byte waits for its copy, every data byte is refused and stores nothing, whatever the buffer-enable bit says.
- R9: A buffered byte accepted in the same cycle that a vblank_i rising edge is acted on is not copied by that edge; it waits for the following rising edge.
- R10: A START or STOP seen partway through a byte discards the partial byte; after a repeated START the next byte is treated as a new address byte.
- R11: An acknowledge pulls the data line low from the falling clock edge after the eighth bit until the falling edge that ends the ninth clock, and only while SCL is low does the pull begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; loads 01H into every register |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| vblank_i | input | 1 | Vertical blanking level; its rising edge releases a buffered byte |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low (acknowledge) |
| regs_o | output | 128 | Live registers, subaddress n in bits 8n+7 down to 8n |

## Verification
Two functions can fall in the same cycle: a buffered data byte's acceptance, at the SCL fall after its eighth bit, and the blanking copy triggered by a vblank_i rising edge. The bench provokes the overlap by raising vblank_i exactly one clock after the eighth falling SCL edge, so both events reach the register bank on the same edge. It judges the result at the ports: the byte must still be acknowledged, the live register must keep its old value through that blanking edge, and the new value must appear only after a second vblank_i pulse.

// File: rtl/vrs_pkg.sv
// Package: shared constants, phase encoding and the reserved-slot test
// for the subaddressed register slave.
package vrs_pkg;

    localparam int unsigned REG_W     = 8;
    localparam int unsigned REG_N     = 16;
    localparam int unsigned SUB_W     = $clog2(REG_N);
    localparam logic [6:0]  DEV_ADDR  = 7'b1000100;
    localparam logic [7:0]  POR_VALUE = 8'h01;
    localparam int unsigned CTRL_IDX  = 12;   // control word holding buffer-enable
    localparam int unsigned BUFEN_BIT = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEVADDR,
        PH_SUBADDR,
        PH_DATA,
        PH_SKIP
    } phase_t;

    // Slots that accept data but never change.
    function automatic logic is_reserved(input int unsigned idx);
        case (idx)
            7, 8, 9, 11, 14, 15: return 1'b1;
            default:             return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/vrs_line_sync.sv
// Bus line front end: brings SCL and SDA into the clock domain with a
// synchroniser chain and derives clock edges and START/STOP events.
// Assumes the bus is slow against clk so every level lasts several cycles.
module vrs_line_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES:0] scl_sh;
    logic [SYNC_STAGES:0] sda_sh;
    logic scl_prev;
    logic sda_prev;

    // Shift both lines through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
        end
    end

    // Derive the current level, the previous level and the events.
    always_comb begin
        scl_lvl   = scl_sh[SYNC_STAGES-1];
        sda_lvl   = sda_sh[SYNC_STAGES-1];
        scl_prev  = scl_sh[SYNC_STAGES];
        sda_prev  = sda_sh[SYNC_STAGES];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/vrs_byte_engine.sv
// Bit engine: collects eight bits on rising SCL edges, reports a finished
// byte on the following falling edge and drives the acknowledge during the
// ninth clock. A START or STOP clears any partial byte.
module vrs_byte_engine #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              ack_want,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              sda_pull
);

    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic              in_ack;
    logic [BYTE_W-1:0] shreg;

    // A byte is complete at the falling edge after its last bit.
    always_comb begin
        byte_done = scl_fall & (bit_cnt == FULL) & ~in_ack;
        byte_val  = shreg;
    end

    // Shift in bits, then hold or release the acknowledge pull.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            in_ack   <= 1'b0;
            shreg    <= '0;
            sda_pull <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt  <= '0;
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            if (scl_rise && !in_ack && bit_cnt != FULL) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (byte_done) begin
                in_ack   <= 1'b1;
                sda_pull <= ack_want;
            end else if (scl_fall && in_ack) begin
                in_ack   <= 1'b0;
                sda_pull <= 1'b0;
                bit_cnt  <= '0;
            end
        end
    end

endmodule

// File: rtl/vrs_xfer_fsm.sv
// Transfer sequencer: walks address, subaddress and data phases, decides
// each acknowledge and issues write requests with the subaddress pointer.
// Assumes byte_done is a single-cycle pulse from the bit engine.
module vrs_xfer_fsm
    import vrs_pkg::*;
#(
    parameter int unsigned REG_W_P = REG_W,
    parameter int unsigned SUB_W_P = SUB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               byte_done,
    input  logic [REG_W_P-1:0] byte_val,
    input  logic               bufen,
    input  logic               pend,
    output logic               ack_want,
    output logic               wr_en,
    output logic               wr_buf,
    output logic [SUB_W_P-1:0] wr_addr,
    output logic [REG_W_P-1:0] wr_data
);

    phase_t             phase;
    logic [SUB_W_P-1:0] ptr;
    logic               first_q;

    // Decide the acknowledge for the byte now completing.
    always_comb begin
        ack_want = 1'b0;
        case (phase)
            PH_DEVADDR: ack_want = (byte_val == {DEV_ADDR, 1'b0});
            PH_SUBADDR: ack_want = ((byte_val >> SUB_W_P) == '0);
            PH_DATA:    ack_want = ~pend & (~bufen | first_q);
            default:    ack_want = 1'b0;
        endcase
        wr_en   = byte_done & (phase == PH_DATA) & ack_want;
        wr_buf  = bufen;
        wr_addr = ptr;
        wr_data = byte_val;
    end

    // Advance the phase and the subaddress pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            ptr     <= '0;
            first_q <= 1'b0;
        end else if (start_det) begin
            phase <= PH_DEVADDR;
        end else if (stop_det) begin
            phase <= PH_IDLE;
        end else if (byte_done) begin
            case (phase)
                PH_DEVADDR: phase <= ack_want ? PH_SUBADDR : PH_SKIP;
                PH_SUBADDR: begin
                    if (ack_want) begin
                        ptr     <= byte_val[SUB_W_P-1:0];
                        first_q <= 1'b1;
                        phase   <= PH_DATA;
                    end else begin
                        phase <= PH_SKIP;
                    end
                end
                PH_DATA: begin
                    if (ack_want) begin
                        ptr     <= ptr + SUB_W_P'(1);
                        first_q <= 1'b0;
                    end else begin
                        phase <= PH_SKIP;
                    end
                end
                default: phase <= phase;
            endcase
        end
    end

endmodule

// File: rtl/vrs_reg_bank.sv
// Register bank: live registers, the single parked byte for buffered mode
// and the blanking edge detector. Reserved slots are fixed at the reset
// value. Assumes vblank_i is slow and needs one capture stage.
module vrs_reg_bank
    import vrs_pkg::*;
#(
    parameter int unsigned REG_N_P = REG_N,
    parameter int unsigned REG_W_P = REG_W,
    parameter int unsigned SUB_W_P = SUB_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vblank_i,
    input  logic                       wr_en,
    input  logic                       wr_buf,
    input  logic [SUB_W_P-1:0]         wr_addr,
    input  logic [REG_W_P-1:0]         wr_data,
    output logic [REG_N_P*REG_W_P-1:0] regs_o,
    output logic                       bufen,
    output logic                       pend,
    output logic                       vb_rise
);

    localparam int unsigned BUFEN_POS = CTRL_IDX * REG_W_P + BUFEN_BIT;

    logic               vb_q;
    logic               vb_d;
    logic [SUB_W_P-1:0] park_addr;
    logic [REG_W_P-1:0] park_data;

    // Capture vblank and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vb_q <= 1'b0;
            vb_d <= 1'b0;
        end else begin
            vb_q <= vblank_i;
            vb_d <= vb_q;
        end
    end

    // Rising blanking edge and the buffer-enable control bit.
    always_comb begin
        vb_rise = vb_q & ~vb_d;
        bufen   = regs_o[BUFEN_POS];
    end

    // Park a buffered byte; the blanking edge retires it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            park_addr <= '0;
            park_data <= '0;
        end else if (wr_en && wr_buf && !is_reserved(int'(wr_addr))) begin
            pend      <= 1'b1;
            park_addr <= wr_addr;
            park_data <= wr_data;
        end else if (vb_rise) begin
            pend <= 1'b0;
        end
    end

    for (genvar g = 0; g < REG_N_P; g++) begin : g_slot
        if (is_reserved(g)) begin : g_fixed
            assign regs_o[g*REG_W_P +: REG_W_P] = REG_W_P'(POR_VALUE);
        end else begin : g_live
            logic [REG_W_P-1:0] cell_q;
            // Load from a direct write or from the parked byte at blanking.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cell_q <= REG_W_P'(POR_VALUE);
                end else if (wr_en && !wr_buf && wr_addr == SUB_W_P'(g)) begin
                    cell_q <= wr_data;
                end else if (vb_rise && pend && park_addr == SUB_W_P'(g)) begin
                    cell_q <= park_data;
                end
            end
            assign regs_o[g*REG_W_P +: REG_W_P] = cell_q;
        end
    end

endmodule

// File: rtl/vrs_regslave.sv
// Top: write-only serial register slave. Joins the line front end, the bit
// engine, the transfer sequencer and the register bank. Assumes clk runs
// many times faster than SCL and that the bus has external pull-ups.
module vrs_regslave
    import vrs_pkg::*;
#(
    parameter int unsigned NREG  = REG_N,
    parameter int unsigned WREG  = REG_W,
    parameter int unsigned NSYNC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic                 vblank_i,
    output logic                 sda_pull_o,
    output logic [NREG*WREG-1:0] regs_o
);

    localparam int unsigned WSUB = $clog2(NREG);

    logic            scl_lvl;
    logic            sda_lvl;
    logic            scl_rise;
    logic            scl_fall;
    logic            start_det;
    logic            stop_det;
    logic            ack_want;
    logic            byte_done;
    logic [WREG-1:0] byte_val;
    logic            bufen;
    logic            pend;
    logic            vb_rise;
    logic            wr_en;
    logic            wr_buf;
    logic [WSUB-1:0] wr_addr;
    logic [WREG-1:0] wr_data;

    vrs_line_sync #(.SYNC_STAGES(NSYNC)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    vrs_byte_engine #(.BYTE_W(WREG)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ack_want  (ack_want),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .sda_pull  (sda_pull_o)
    );

    vrs_xfer_fsm #(.REG_W_P(WREG), .SUB_W_P(WSUB)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .bufen     (bufen),
        .pend      (pend),
        .ack_want  (ack_want),
        .wr_en     (wr_en),
        .wr_buf    (wr_buf),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    vrs_reg_bank #(.REG_N_P(NREG), .REG_W_P(WREG), .SUB_W_P(WSUB)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .vblank_i (vblank_i),
        .wr_en    (wr_en),
        .wr_buf   (wr_buf),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .regs_o   (regs_o),
        .bufen    (bufen),
        .pend     (pend),
        .vb_rise  (vb_rise)
    );

endmodule

// File: rtl/vrs_regslave_chk.sv
// Checker for vrs_regslave: timing of the acknowledge pull, causes of live
// register changes and the life of the parked byte. Attached by bind.
module vrs_regslave_chk
    import vrs_pkg::*;
#(
    parameter int unsigned NREG = REG_N,
    parameter int unsigned WREG = REG_W,
    parameter int unsigned WSUB = $clog2(NREG)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_lvl,
    input logic                 sda_pull_o,
    input logic [NREG*WREG-1:0] regs_o,
    input logic                 pend,
    input logic                 vb_rise,
    input logic                 wr_en,
    input logic                 wr_buf,
    input logic [WSUB-1:0]      wr_addr
);

    AST_ACK_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_lvl); // R11

    AST_LIVE_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> ($past(wr_en && !wr_buf) || $past(vb_rise && pend))); // R7

    AST_NO_WRITE_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !wr_en); // R8

    AST_PARK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && vb_rise) |=> !pend); // R7

    AST_SAME_EDGE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_buf && vb_rise && !is_reserved(int'(wr_addr))) |=> pend); // R9

endmodule

bind vrs_regslave vrs_regslave_chk #(.NREG(NREG), .WREG(WREG)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (scl_lvl),
    .sda_pull_o (sda_pull_o),
    .regs_o     (regs_o),
    .pend       (pend),
    .vb_rise    (vb_rise),
    .wr_en      (wr_en),
    .wr_buf     (wr_buf),
    .wr_addr    (wr_addr)
);

// File: tb/vrs_regslave_tb_top.sv
// Scoreboard bench: the bus driver queues the expected acknowledge of each
// byte and a monitor compares it against sda_pull_o in the ninth clock.
module vrs_regslave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;        // clk cycles per quarter bus bit
    localparam int WD_LIMIT   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         vblank = 1'b0;
    logic         sda_pull_o;
    logic [127:0] regs_o;
    logic         ack_strobe = 1'b0;
    logic         sda_bus;

    int n_vec = 0;
    int n_bad = 0;
    bit exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull_o;

    vrs_regslave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .vblank_i   (vblank),
        .sda_pull_o (sda_pull_o),
        .regs_o     (regs_o)
    );

    // Monitor: pop one expected acknowledge per strobe and compare.
    always @(posedge ack_strobe) begin
        if (exp_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL scoreboard empty, got pull %b", sda_pull_o);
        end else begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (sda_pull_o !== e) begin
                n_bad++;
                $display("FAIL %s ack: got %b expected %b", t, sda_pull_o, e);
            end
        end
    end

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bit(input bit b, input bit collide);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0;
        if (collide) begin
            @(negedge clk);
            vblank = 1'b1;
            repeat (QTR-1) @(negedge clk);
        end else begin
            wait_q();
        end
    endtask

    // Driver: send a byte, queue its expected acknowledge, strobe the monitor.
    task automatic send_byte(input logic [7:0] d, input bit ack, input string tag,
                             input bit collide = 1'b0);
        for (int i = 7; i >= 0; i--) send_bit(d[i], collide && (i == 0));
        exp_q.push_back(ack);
        tag_q.push_back(tag);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        ack_strobe = 1'b1;
        @(negedge clk) ack_strobe = 1'b0;
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic vblank_pulse();
        vblank = 1'b1; repeat (6) @(negedge clk);
        vblank = 1'b0; repeat (6) @(negedge clk);
    endtask

    task automatic check_reg(input int idx, input logic [7:0] exp, input string tag);
        n_vec++;
        if (regs_o[idx*8 +: 8] !== exp) begin
            n_bad++;
            $display("FAIL %s reg %0h: got %02h expected %02h", tag, idx, regs_o[idx*8 +: 8], exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin : stimulus
        repeat (5) @(negedge clk);
        // R1: reset state held and after release
        for (int i = 0; i < 16; i++) check_reg(i, 8'h01, "R1 in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 16; i++) check_reg(i, 8'h01, "R1 after reset");
        n_vec++;
        if (sda_pull_o !== 1'b0) begin
            n_bad++; $display("FAIL R1 pull: got %b expected 0", sda_pull_o);
        end

        // R2: wrong device addresses are refused, rest ignored
        start_c(); send_byte(8'h89, 1'b0, "R2 read addr"); send_byte(8'h02, 1'b0, "R2 skip"); stop_c();
        start_c(); send_byte(8'h90, 1'b0, "R2 other addr"); send_byte(8'h02, 1'b0, "R2 skip sub");
        send_byte(8'h5A, 1'b0, "R2 skip data"); stop_c();
        check_reg(2, 8'h01, "R2 no store");

        // R4 R5: burst through reserved slots with wrap
        start_c(); send_byte(8'h88, 1'b1, "R2 addr"); send_byte(8'h0E, 1'b1, "R3 sub 0E");
        send_byte(8'hA1, 1'b1, "R5 data 0E"); send_byte(8'hB2, 1'b1, "R5 data 0F");
        send_byte(8'hC3, 1'b1, "R4 wrap 00"); send_byte(8'hD4, 1'b1, "R4 data 01"); stop_c();
        check_reg(14, 8'h01, "R5 0E kept"); check_reg(15, 8'h01, "R5 0F kept");
        check_reg(0, 8'hC3, "R4 wrap"); check_reg(1, 8'hD4, "R4 increment");

        // R3: subaddress above range
        start_c(); send_byte(8'h88, 1'b1, "R2 addr"); send_byte(8'h10, 1'b0, "R3 sub 10");
        send_byte(8'hEE, 1'b0, "R3 data skip"); stop_c();
        check_reg(0, 8'hC3, "R3 no store");

        // R4: single immediate write, then set buffer-enable
        start_c(); send_byte(8'h88, 1'b1, "R2 addr"); send_byte(8'h04, 1'b1, "R3 sub 04");
        send_byte(8'h3F, 1'b1, "R4 data"); stop_c();
        check_reg(4, 8'h3F, "R4 immediate");
        start_c(); send_byte(8'h88, 1'b1, "R2 addr"); send_byte(8'h0C, 1'b1, "R3 sub 0C");
        send_byte(8'h20, 1'b1, "R4 bufen on"); stop_c();
        check_reg(12, 8'h20, "R4 ctrl word");

        // R6 R7: buffered, single byte per transfer
        start_c(); send_byte(8'h88, 1'b1, "R2 addr"); send_byte(8'h02, 1'b1, "R3 sub 02");
        send_byte(8'h55, 1'b1, "R6 first"); send_byte(8'h66, 1'b0, "R6 second"); stop_c();
        check_reg(2, 8'h01, "R7 held"); check_reg(3, 8'h01, "R6 no store");

        // R8: pending blocks data
        start_c(); send_byte(8'h88, 1'b1, "R2 addr"); send_byte(8'h05, 1'b1, "R3 sub 05");
        send_byte(8'h77, 1'b0, "R8 refused"); stop_c();
        vblank_pulse();
        check_reg(2, 8'h55, "R7 copied"); check_reg(5, 8'h01, "R8 no store");

        // R9: acceptance on the same edge as the blanking copy
        start_c(); send_byte(8'h88, 1'b1, "R2 addr"); send_byte(8'h06, 1'b1, "R3 sub 06");
        send_byte(8'h9A, 1'b1, "R9 collide", 1'b1);
        vblank = 1'b0;
        stop_c();
        check_reg(6, 8'h01, "R9 not copied yet");
        vblank_pulse();
        check_reg(6, 8'h9A, "R9 copied later");

        // Clear buffer-enable through a buffered write
        start_c(); send_byte(8'h88, 1'b1, "R2 addr"); send_byte(8'h0C, 1'b1, "R3 sub 0C");
        send_byte(8'h00, 1'b1, "R7 bufen off"); stop_c();
        check_reg(12, 8'h20, "R7 ctrl held");
        vblank_pulse();
        check_reg(12, 8'h00, "R7 ctrl copied");

        // R10: STOP mid-byte, then repeated START mid-byte
        start_c(); send_byte(8'h88, 1'b1, "R2 addr"); send_byte(8'h02, 1'b1, "R3 sub 02");
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        stop_c();
        check_reg(2, 8'h55, "R10 stop abort");
        start_c();
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
        start_c(); send_byte(8'h88, 1'b1, "R10 restart addr"); send_byte(8'h03, 1'b1, "R3 sub 03");
        send_byte(8'h11, 1'b1, "R10 data"); stop_c();
        check_reg(3, 8'h11, "R10 restart write");

        repeat (10) @(negedge clk);
        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++; $display("FAIL R11 leftover acks: got %0d expected 0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule